// File: doc/BRIEF.md
# Three-Wire Display Controller Host Interface

This block is the serial slave that a host microcontroller uses to reach a character/segment display controller. The host holds an active-low select, toggles a write strobe and a read strobe, and shares one data line with the block. Every transfer opens with a three-bit mode code. That code chooses one of four streams:

- a burst read of a 256-entry by 4-bit display memory;
- a burst write of that memory;
- a read-modify-write pass over that memory;
- a chain of 9-bit configuration commands.

The block decodes each command into a small bank of configuration levels and one-clock clear pulses. The timer, watchdog, tone and display drive logic elsewhere in the chip consume these outputs.

All strobe, select and data pins are asynchronous to the block clock. They pass through a synchronizer, and edges are found inside the block, so the system clock must run at least four times faster than the strobe toggle rate. The display drive logic reads the memory through a separate combinational scan port, which never competes with the serial side. The serial data output is split into a value and an output enable, and the pad sits outside the block.

Top module: `lcd_serial_host_if`

## Requirements
- R1: After reset the configuration outputs are all 0: system off, display off, timer off, watchdog off, tone off, tone select 2 kHz (tone_4k=0), IRQ off, internal clock (ext_clk=0), rate 0. sdo_oe is 0 and no clear pulse is present.
- R2: The first three bits written after select falls form the mode code. 110 is read, 101 is write or read-modify-write, and 100 is command. Any other code makes the rest of that select period ignored, so the memory and configuration stay unchanged.
- R3: In write mode, an 8-bit address follows, sent MSB first. A 4-bit nibble follows it, sent bit 0 first. Each bit is taken on a rising write strobe, and the nibble lands at that address, where the scan port shows it.
- R4: Further nibbles under the same select go to consecutive addresses. The address wraps from 255 to 0.
- R5: In read mode, each rising read strobe drives the next bit of the nibble at the current address, bit 0 first, with sdo_oe=1. sdo_oe returns to 0 on any falling strobe or when select rises.
- R6: A read burst returns consecutive addresses, advancing after every fourth bit.
- R7: Under code 101, four read strobes at a nibble boundary return the stored nibble. The next four write strobes then store a new nibble at the same address, and only after that does the address advance.
- R8: A command is 9 bits, sent first bit first, and the last bit is ignored. The first eight bits select the action. Commands chain under one select without a new mode code.
- R9: 00001101 gives exactly one one-clock pulse on clr_timer, and 00001111 gives exactly one on clr_wdt.
- R10: Select high aborts the transfer. A partial nibble is discarded, and the first three bits of the next select period are again a mode code.
- R11: The following codes are decoded, with x meaning don't-care:
  - 00000000 and 00000001 set system off and on.
  - 00000010 and 00000011 set display off and on.
  - 00000100 and 00000110 set timer off and on.
  - 00000101 and 00000111 set watchdog off and on.
  - 00001000 turns the tone off.
  - 010xxxxx turns the tone on at 4 kHz, and 0110xxxx turns it on at 2 kHz.
  - 000110xx selects the internal clock, and 000111xx the external clock.
  - 100x0xxx disables IRQ, and 100x1xxx enables it.
  - 101x0nnn sets the rate to nnn.
- R12: Codes 111xxxxx (test and normal mode) and all other unlisted codes leave every configuration output unchanged and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from host |
| wr_n | input | 1 | Write strobe, bits taken on rising edge |
| rd_n | input | 1 | Read strobe, bits driven on rising edge |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for the shared data pad |
| scan_addr | input | ADDR_W | Display scan read address |
| scan_data | output | DATA_W | Nibble stored at scan_addr |
| sys_en | output | 1 | System oscillator on |
| lcd_en | output | 1 | Display drive on |
| timer_en | output | 1 | Time-base output on |
| wdt_en | output | 1 | Watchdog flag output on |
| tone_en | output | 1 | Tone output on |
| tone_4k | output | 1 | Tone at 4 kHz (else 2 kHz) |
| irq_en | output | 1 | Interrupt output on |
| ext_clk | output | 1 | External clock source chosen |
| tb_rate | output | 3 | Time-base rate select |
| clr_timer | output | 1 | One-clock time-base clear |
| clr_wdt | output | 1 | One-clock watchdog clear |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 4-bit nibble and two synchronizer stages. With an 8-bit address, the full 256-entry memory is in play, so a burst that starts at 254 exercises the wrap to address 0 in both write and read. Strobe half-periods of six clocks keep the sync-plus-edge latency inside each half. This lets the bench sample the data line and its enable at a fixed point after each read strobe rise.

// File: rtl/lcdsi_pkg.sv
package lcdsi_pkg;
  localparam int ID_W   = 3;
  localparam int CODE_W = 8;
  localparam int CMD_W  = CODE_W + 1;
  localparam int RATE_W = 3;

  localparam logic [ID_W-1:0] MODE_READ  = 3'b110;
  localparam logic [ID_W-1:0] MODE_WRITE = 3'b101;
  localparam logic [ID_W-1:0] MODE_CMD   = 3'b100;

  typedef enum logic [2:0] {
    ST_ID, ST_ADDR, ST_RD, ST_WR, ST_RMW_R, ST_RMW_W, ST_CMD, ST_SKIP
  } sif_state_e;

  typedef struct packed {
    logic              sys_en;
    logic              lcd_en;
    logic              timer_en;
    logic              wdt_en;
    logic              tone_en;
    logic              tone_4k;
    logic              irq_en;
    logic              ext_clk;
    logic [RATE_W-1:0] tb_rate;
  } cfg_t;

  localparam cfg_t CFG_RESET = '0;
endpackage

// File: rtl/lcdsi_sync.sv
module lcdsi_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lcdsi_ram.sv
module lcdsi_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/lcdsi_serial.sv
module lcdsi_serial
  import lcdsi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_q,
  input  logic              wr_q,
  input  logic              rd_q,
  input  logic              din,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              dout,
  output logic              dout_oe,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code
);
  localparam int MAXN_A = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
  localparam int MAXN   = (MAXN_A > DATA_W) ? MAXN_A : DATA_W;
  localparam int CNT_W  = $clog2(MAXN);
  localparam int BIT_W  = $clog2(DATA_W);

  sif_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ID_W-1:0]   id_q;
  logic              rd_mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] nib_q;
  logic [CODE_W-1:0] sh_q;
  logic              wr_prev, rd_prev;

  logic              wr_rise, rd_rise, any_fall;
  logic [ID_W-1:0]   id_full;
  logic [DATA_W-1:0] nib_next;
  logic [BIT_W-1:0]  idx;
  logic              last_id, last_addr, last_nib, last_cmd;

  assign wr_rise  = wr_q & ~wr_prev;
  assign rd_rise  = rd_q & ~rd_prev;
  assign any_fall = (~wr_q & wr_prev) | (~rd_q & rd_prev);
  assign idx      = cnt_q[BIT_W-1:0];
  assign id_full  = {id_q[ID_W-2:0], din};
  assign last_id   = (cnt_q == CNT_W'(ID_W - 1));
  assign last_addr = (cnt_q == CNT_W'(ADDR_W - 1));
  assign last_nib  = (cnt_q == CNT_W'(DATA_W - 1));
  assign last_cmd  = (cnt_q == CNT_W'(CMD_W - 1));

  always_comb begin
    nib_next      = nib_q;
    nib_next[idx] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ID;
      cnt_q     <= '0;
      id_q      <= '0;
      rd_mode_q <= 1'b0;
      addr_q    <= '0;
      nib_q     <= '0;
      sh_q      <= '0;
      wr_prev   <= 1'b1;
      rd_prev   <= 1'b1;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
      dout      <= 1'b0;
      dout_oe   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      wr_prev   <= wr_q;
      rd_prev   <= rd_q;
      ram_we    <= 1'b0;
      cmd_valid <= 1'b0;
      if (any_fall) dout_oe <= 1'b0;
      if (cs_q) begin
        state_q <= ST_ID;
        cnt_q   <= '0;
        dout_oe <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ID: if (wr_rise) begin
            id_q <= id_full;
            if (last_id) begin
              cnt_q <= '0;
              if (id_full == MODE_READ) begin
                state_q <= ST_ADDR; rd_mode_q <= 1'b1;
              end else if (id_full == MODE_WRITE) begin
                state_q <= ST_ADDR; rd_mode_q <= 1'b0;
              end else if (id_full == MODE_CMD) begin
                state_q <= ST_CMD;
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: if (wr_rise) begin
            addr_q <= {addr_q[ADDR_W-2:0], din};
            if (last_addr) begin
              cnt_q   <= '0;
              state_q <= rd_mode_q ? ST_RD : ST_WR;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD: if (rd_rise) begin
            dout    <= ram_rdata[idx];
            dout_oe <= 1'b1;
            if (last_nib) begin
              cnt_q  <= '0;
              addr_q <= addr_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WR, ST_RMW_W: begin
            if (wr_rise) begin
              nib_q <= nib_next;
              if (last_nib) begin
                ram_we    <= 1'b1;
                ram_waddr <= addr_q;
                ram_wdata <= nib_next;
                addr_q    <= addr_q + 1'b1;
                cnt_q     <= '0;
                state_q   <= ST_WR;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else if (rd_rise && state_q == ST_WR && cnt_q == '0) begin
              dout    <= ram_rdata[0];
              dout_oe <= 1'b1;
              cnt_q   <= CNT_W'(1);
              state_q <= ST_RMW_R;
            end
          end
          ST_RMW_R: if (rd_rise) begin
            dout    <= ram_rdata[idx];
            dout_oe <= 1'b1;
            if (last_nib) begin
              cnt_q   <= '0;
              state_q <= ST_RMW_W;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_CMD: if (wr_rise) begin
            if (last_cmd) begin
              cmd_valid <= 1'b1;
              cmd_code  <= sh_q;
              cnt_q     <= '0;
            end else begin
              sh_q  <= {sh_q[CODE_W-2:0], din};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_SKIP: ;
          default: state_q <= ST_ID;
        endcase
      end
    end
  end

  assign ram_raddr = addr_q;
endmodule

// File: rtl/lcdsi_cmd.sv
module lcdsi_cmd
  import lcdsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output cfg_t              cfg,
  output logic              clr_timer,
  output logic              clr_wdt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= CFG_RESET;
      clr_timer <= 1'b0;
      clr_wdt   <= 1'b0;
    end else begin
      clr_timer <= 1'b0;
      clr_wdt   <= 1'b0;
      if (cmd_valid) begin
        casez (cmd_code)
          8'b0000_0000: cfg.sys_en   <= 1'b0;
          8'b0000_0001: cfg.sys_en   <= 1'b1;
          8'b0000_0010: cfg.lcd_en   <= 1'b0;
          8'b0000_0011: cfg.lcd_en   <= 1'b1;
          8'b0000_0100: cfg.timer_en <= 1'b0;
          8'b0000_0101: cfg.wdt_en   <= 1'b0;
          8'b0000_0110: cfg.timer_en <= 1'b1;
          8'b0000_0111: cfg.wdt_en   <= 1'b1;
          8'b0000_1000: cfg.tone_en  <= 1'b0;
          8'b0000_1101: clr_timer    <= 1'b1;
          8'b0000_1111: clr_wdt      <= 1'b1;
          8'b0001_10??: cfg.ext_clk  <= 1'b0;
          8'b0001_11??: cfg.ext_clk  <= 1'b1;
          8'b010?_????: begin cfg.tone_en <= 1'b1; cfg.tone_4k <= 1'b1; end
          8'b0110_????: begin cfg.tone_en <= 1'b1; cfg.tone_4k <= 1'b0; end
          8'b100?_0???: cfg.irq_en   <= 1'b0;
          8'b100?_1???: cfg.irq_en   <= 1'b1;
          8'b101?_0???: cfg.tb_rate  <= cmd_code[RATE_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_serial_host_if.sv
module lcd_serial_host_if
  import lcdsi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [DATA_W-1:0] scan_data,
  output logic              sys_en,
  output logic              lcd_en,
  output logic              timer_en,
  output logic              wdt_en,
  output logic              tone_en,
  output logic              tone_4k,
  output logic              irq_en,
  output logic              ext_clk,
  output logic [2:0]        tb_rate,
  output logic              clr_timer,
  output logic              clr_wdt
);
  localparam int PINS = 4;

  logic [PINS-1:0]   pins_q;
  logic              cs_q, wr_q, rd_q, din_q;
  logic [ADDR_W-1:0] ram_raddr, ram_waddr;
  logic [DATA_W-1:0] ram_rdata, ram_wdata;
  logic              ram_we;
  logic              cmd_valid;
  logic [CODE_W-1:0] cmd_code;
  cfg_t              cfg;

  lcdsi_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, wr_n, rd_n, sdi}), .q(pins_q)
  );
  assign {cs_q, wr_q, rd_q, din_q} = pins_q;

  lcdsi_serial #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .wr_q(wr_q), .rd_q(rd_q),
    .din(din_q), .ram_rdata(ram_rdata), .ram_raddr(ram_raddr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .dout(sdo), .dout_oe(sdo_oe), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  lcdsi_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(ram_raddr), .rdata_a(ram_rdata),
    .raddr_b(scan_addr), .rdata_b(scan_data)
  );

  lcdsi_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cfg(cfg), .clr_timer(clr_timer), .clr_wdt(clr_wdt)
  );

  assign sys_en   = cfg.sys_en;
  assign lcd_en   = cfg.lcd_en;
  assign timer_en = cfg.timer_en;
  assign wdt_en   = cfg.wdt_en;
  assign tone_en  = cfg.tone_en;
  assign tone_4k  = cfg.tone_4k;
  assign irq_en   = cfg.irq_en;
  assign ext_clk  = cfg.ext_clk;
  assign tb_rate  = cfg.tb_rate;
endmodule

// File: rtl/lcdsi_chk.sv
module lcdsi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_q,
  input logic        sdo_oe,
  input logic        ram_we,
  input logic        cmd_valid,
  input logic [10:0] cfg_vec,
  input logic        clr_timer,
  input logic        clr_wdt
);
  // R5
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> !sdo_oe);
  // R10
  we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !$past(cs_q));
  // R9
  clr_timer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_timer |=> !clr_timer);
  // R9
  clr_wdt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> !clr_wdt);
  // R9
  clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_timer && clr_wdt));
  // R9
  clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_timer || clr_wdt) |-> $past(cmd_valid));
  // R8
  cfg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_vec) |-> $past(cmd_valid));
endmodule

bind lcd_serial_host_if lcdsi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .sdo_oe(sdo_oe), .ram_we(ram_we),
  .cmd_valid(cmd_valid), .cfg_vec(cfg), .clr_timer(clr_timer), .clr_wdt(clr_wdt)
);

// File: tb/lcd_serial_host_if_bench.sv
module lcd_serial_host_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, sdi = 1'b1;
  logic sdo, sdo_oe;
  logic [7:0] scan_addr = '0;
  logic [3:0] scan_data;
  logic sys_en, lcd_en, timer_en, wdt_en, tone_en, tone_4k, irq_en, ext_clk;
  logic [2:0] tb_rate;
  logic clr_timer, clr_wdt;

  int total = 0, fails = 0, n_ct = 0, n_cw = 0;
  logic [10:0] exp_cfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_serial_host_if u_lcd_serial_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .scan_addr(scan_addr), .scan_data(scan_data),
    .sys_en(sys_en), .lcd_en(lcd_en), .timer_en(timer_en), .wdt_en(wdt_en),
    .tone_en(tone_en), .tone_4k(tone_4k), .irq_en(irq_en), .ext_clk(ext_clk),
    .tb_rate(tb_rate), .clr_timer(clr_timer), .clr_wdt(clr_wdt)
  );

  always @(negedge clk) begin
    if (clr_timer) n_ct++;
    if (clr_wdt) n_cw++;
  end

  function automatic logic [10:0] cfg_now();
    return {sys_en, lcd_en, timer_en, wdt_en, tone_en, tone_4k, irq_en, ext_clk, tb_rate};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on();
    tick(4); cs_n = 1'b0; tick(HALF);
  endtask

  task automatic sel_off();
    tick(HALF); cs_n = 1'b1; tick(8);
  endtask

  task automatic wbit(input logic b);
    sdi = b; wr_n = 1'b0; tick(HALF); wr_n = 1'b1; tick(HALF);
  endtask

  task automatic wbits(input logic [8:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) wbit(v[i]);
  endtask

  task automatic wnib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wbit(v[i]);
  endtask

  task automatic rnib(output logic [3:0] v, output bit oe_ok);
    oe_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_n = 1'b0; tick(HALF); rd_n = 1'b1; tick(HALF);
      v[i] = sdo;
      if (sdo_oe !== 1'b1) oe_ok = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    wbits({c, c[0]}, 9);
  endtask

  task automatic scan_chk(input logic [7:0] a, input logic [3:0] e, input string req);
    scan_addr = a; tick(1);
    check(scan_data === e, req, scan_data, e);
  endtask

  task automatic write_one(input logic [7:0] a, input logic [3:0] v);
    sel_on(); wbits(9'b101, 3); wbits({1'b0, a}, 8); wnib(v); sel_off();
  endtask

  task automatic t_reset();
    check(cfg_now() === 11'h0, "R1 cfg", cfg_now(), 0);
    check(sdo_oe === 1'b0, "R1 oe", sdo_oe, 0);
    check(!clr_timer && !clr_wdt, "R1 pulses", {clr_timer, clr_wdt}, 0);
  endtask

  task automatic t_write_read();
    logic [3:0] v; bit ok;
    write_one(8'h3C, 4'hA);
    scan_chk(8'h3C, 4'hA, "R3 write");
    write_one(8'h3D, 4'h5);
    sel_on(); wbits(9'b110, 3); wbits(9'h03C, 8); rnib(v, ok);
    check(v === 4'hA, "R5 read nibble", v, 4'hA);
    check(ok, "R5 oe high", ok, 1);
    rd_n = 1'b0; tick(HALF);
    check(sdo_oe === 1'b0, "R5 oe low after fall", sdo_oe, 0);
    rd_n = 1'b1; tick(HALF);
    rnib(v, ok); v[0] = v[0];
    sel_off();
    check(sdo_oe === 1'b0, "R5 oe low after select", sdo_oe, 0);
  endtask

  task automatic t_burst();
    logic [3:0] v; bit ok;
    sel_on(); wbits(9'b101, 3); wbits(9'h0FE, 8);
    wnib(4'h1); wnib(4'h2); wnib(4'h3); sel_off();
    scan_chk(8'hFE, 4'h1, "R4 burst 254");
    scan_chk(8'hFF, 4'h2, "R4 burst 255");
    scan_chk(8'h00, 4'h3, "R4 wrap 0");
    sel_on(); wbits(9'b110, 3); wbits(9'h0FF, 8);
    rnib(v, ok); check(v === 4'h2, "R6 burst read 255", v, 2);
    rnib(v, ok); check(v === 4'h3, "R6 burst read wrap", v, 3);
    sel_off();
  endtask

  task automatic t_rmw();
    logic [3:0] v; bit ok;
    write_one(8'h10, 4'h5);
    write_one(8'h11, 4'h9);
    sel_on(); wbits(9'b101, 3); wbits(9'h010, 8);
    rnib(v, ok); check(v === 4'h5, "R7 rmw old 0x10", v, 5);
    wnib(4'hC);
    rnib(v, ok); check(v === 4'h9, "R7 rmw old 0x11", v, 9);
    wnib(4'h6);
    sel_off();
    scan_chk(8'h10, 4'hC, "R7 rmw new 0x10");
    scan_chk(8'h11, 4'h6, "R7 rmw new 0x11");
  endtask

  task automatic t_cmd_chain();
    sel_on(); wbits(9'b100, 3);
    cmd(8'h01); cmd(8'h03); cmd(8'h06); cmd(8'h07); cmd(8'h88);
    sel_off();
    exp_cfg = 11'b1111_0010_000;
    check(cfg_now() === exp_cfg, "R8 chain", cfg_now(), exp_cfg);
    sel_on(); wbits(9'b100, 3); cmd(8'h04); cmd(8'h00); sel_off();
    exp_cfg = 11'b0101_0010_000;
    check(cfg_now() === exp_cfg, "R8 off codes", cfg_now(), exp_cfg);
  endtask

  task automatic t_cmd_misc();
    sel_on(); wbits(9'b100, 3);
    cmd(8'h5A); cmd(8'h1E); cmd(8'hA5); cmd(8'h80);
    sel_off();
    exp_cfg = 11'b0101_1101_101;
    check(cfg_now() === exp_cfg, "R11 tone4k ext rate irq", cfg_now(), exp_cfg);
    sel_on(); wbits(9'b100, 3);
    cmd(8'h65); cmd(8'h19); cmd(8'hB3); cmd(8'h05);
    sel_off();
    exp_cfg = 11'b0100_1000_011;
    check(cfg_now() === exp_cfg, "R11 tone2k int rate wdt", cfg_now(), exp_cfg);
    sel_on(); wbits(9'b100, 3); cmd(8'h08); sel_off();
    exp_cfg = 11'b0100_0000_011;
    check(cfg_now() === exp_cfg, "R11 tone off", cfg_now(), exp_cfg);
  endtask

  task automatic t_clear();
    int ct0, cw0;
    ct0 = n_ct; cw0 = n_cw;
    sel_on(); wbits(9'b100, 3); cmd(8'h0D); cmd(8'h0F); cmd(8'h0D); sel_off();
    check(n_ct - ct0 == 2, "R9 timer clears", n_ct - ct0, 2);
    check(n_cw - cw0 == 1, "R9 wdt clears", n_cw - cw0, 1);
  endtask

  task automatic t_ignored();
    int ct0, cw0;
    ct0 = n_ct; cw0 = n_cw;
    sel_on(); wbits(9'b100, 3);
    cmd(8'hE0); cmd(8'hE3); cmd(8'hFF); cmd(8'h0A); cmd(8'hC8);
    sel_off();
    check(cfg_now() === exp_cfg, "R12 cfg kept", cfg_now(), exp_cfg);
    check(n_ct == ct0 && n_cw == cw0, "R12 no pulse", n_ct + n_cw, ct0 + cw0);
  endtask

  task automatic t_abort_badid();
    write_one(8'h20, 4'h7);
    sel_on(); wbits(9'b111, 3); wbits(9'h020, 8); wnib(4'hF); sel_off();
    scan_chk(8'h20, 4'h7, "R2 bad mode ignored");
    sel_on(); wbits(9'b101, 3); wbits(9'h020, 8); wbit(1'b0); wbit(1'b0); sel_off();
    scan_chk(8'h20, 4'h7, "R10 partial discarded");
    sel_on(); wbits(9'b100, 3); wbits(9'h003, 5); sel_off();
    sel_on(); wbits(9'b101, 3); wbits(9'h021, 8); wnib(4'h4); sel_off();
    scan_chk(8'h21, 4'h4, "R10 fresh mode after abort");
    check(cfg_now() === exp_cfg, "R10 partial cmd no effect", cfg_now(), exp_cfg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_write_read();
    t_burst();
    t_rmw();
    t_cmd_chain();
    t_cmd_misc();
    t_clear();
    t_ignored();
    t_abort_badid();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule